// File: doc/BRIEF.md
# I3C Target Common Command Write Handler

This block is the command layer of an I3C target device. A byte-level bus front end has already decoded the wire activity, and it hands the block one-cycle event pulses: frame start, repeated start, stop, address header (7-bit address plus read/write bit), and written data byte. The block follows the frame structure, recognises Common Command Codes carried in writes to the broadcast address `0x7E`, and applies the write-type commands to its configuration state. That state covers the dynamic address, the event-enable mask, the maximum write and read lengths, and the reset-action byte. For every address header it returns an acknowledge decision one cycle later.

A code byte below `0x80` is a broadcast command, and it acts on the payload bytes that follow it in the same `0x7E` section. A code byte of `0x80` or above opens a direct command. The direct command applies only to later sections of the frame that are addressed to this target. Its scope ends at the next `0x7E` header, at a frame start, or at a stop. When the dynamic address is cleared and a static address is configured, the target answers at its static address in legacy mode.

Top module: `i3c_tgt_ccc_wr`

## Requirements
- R1: After reset, `dyn_valid` is 0, `evt_en` equals `EVT_RST` (default 0x0B), `max_wr_len` and `max_rd_len` equal their reset parameters (default 0x0100), `rst_action` is 0, and `hdr_ack_vld` is 0.
- R2: Each `ev_hdr` pulse is followed exactly one cycle later by a single `hdr_ack_vld` pulse. `hdr_ack` is 1 for a write to 0x7E, and for the current dynamic address while `dyn_valid` is 1. `hdr_ack` is 0 for any other address.
- R3: Broadcast code 0x06 clears `dyn_valid`. `legacy_mode` equals `static_valid` AND NOT `dyn_valid`. In legacy mode, headers to `static_addr` are acknowledged.
- R4: While direct code 0x86 is in scope, a header to the target's dynamic address gets `hdr_ack`=0, and the dynamic address and `dyn_valid` keep their values.
- R5: Code 0x00 (broadcast) or 0x80 (direct) sets every `evt_en` bit that is 1 in the first payload byte.
- R6: Code 0x01 (broadcast) or 0x81 (direct) clears every `evt_en` bit that is 1 in the first payload byte.
- R7: Codes 0x09/0x89 load `max_wr_len`, and 0x0A/0x8A load `max_rd_len`, from the first two payload bytes, with the first byte as bits 15:8. Nothing changes if the stop comes after only one byte. Bytes beyond the second are ignored.
- R8: Broadcast code 0x2A stores its first payload byte in `rst_action`. Direct code 0x9A captures the byte after the code, and stores it only when a write header to the target's own address follows within the scope.
- R9: Direct code 0x88 followed by an acknowledged write header to the current dynamic address takes bits 7:1 of the first byte of that section as the new dynamic address.
- R10: Broadcast code 0x29 copies `static_addr` into the dynamic address and sets `dyn_valid` when `static_valid` is 1.
- R11: A direct command's payload sent to any other address, or sent after the scope has ended (0x7E header or stop), changes no register.
- R12: A data byte that arrives together with `ev_stop` is applied before the stop takes effect. A header that arrives together with `ev_start`/`ev_rstart` is judged with the registers as updated by the byte before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Frame start pulse |
| ev_rstart | input | 1 | Repeated start pulse |
| ev_stop | input | 1 | Stop pulse |
| ev_hdr | input | 1 | Address header pulse |
| hdr_addr | input | 7 | Header address |
| hdr_rnw | input | 1 | Header read (1) / write (0) |
| ev_byte | input | 1 | Written data byte pulse |
| byte_data | input | 8 | Data byte value |
| static_addr | input | 7 | Configured static address |
| static_valid | input | 1 | Static address present |
| hdr_ack_vld | output | 1 | Acknowledge decision valid |
| hdr_ack | output | 1 | 1 = ACK, 0 = NACK |
| dyn_addr | output | 7 | Dynamic address |
| dyn_valid | output | 1 | Dynamic address assigned |
| legacy_mode | output | 1 | Target answers as a legacy device |
| evt_en | output | 8 | Event-enable mask |
| max_wr_len | output | 16 | Maximum write length |
| max_rd_len | output | 16 | Maximum read length |
| rst_action | output | 8 | Reset-action byte |

## Verification
Two functions can coincide in one cycle. The last length byte can arrive on the same pulse as the stop that tears down the frame context. A header that opens a new section can also arrive in the cycle right after the byte that changed the dynamic address. The bench provokes the first case by driving the second SETMWL-type byte together with `ev_stop`, and judges it by the committed 16-bit length. It provokes the second case by following a new-address byte directly with a repeated start and a header to the new address. That header must be acknowledged, and the old address must then be refused.

// File: rtl/i3c_ccc_pkg.sv
package i3c_ccc_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

  typedef enum logic [3:0] {
    CMD_NONE,
    CMD_ENEC,
    CMD_DISEC,
    CMD_RSTDAA,
    CMD_SETMWL,
    CMD_SETMRL,
    CMD_SETAASA,
    CMD_RSTACT,
    CMD_SETNEWDA
  } ccc_cmd_e;

  // Map a code byte to a command; broadcast and direct forms share a command.
  function automatic ccc_cmd_e ccc_decode(input logic [BYTE_W-1:0] code);
    case (code)
      8'h00, 8'h80: return CMD_ENEC;
      8'h01, 8'h81: return CMD_DISEC;
      8'h06, 8'h86: return CMD_RSTDAA;
      8'h09, 8'h89: return CMD_SETMWL;
      8'h0A, 8'h8A: return CMD_SETMRL;
      8'h29:        return CMD_SETAASA;
      8'h2A, 8'h9A: return CMD_RSTACT;
      8'h88:        return CMD_SETNEWDA;
      default:      return CMD_NONE;
    endcase
  endfunction

  function automatic logic ccc_is_direct(input logic [BYTE_W-1:0] code);
    return code[BYTE_W-1];
  endfunction

  function automatic logic [2*BYTE_W-1:0] len_join(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] evt_apply(input logic [BYTE_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] mask,
                                                  input logic              set);
    return set ? (cur | mask) : (cur & ~mask);
  endfunction

  function automatic logic [ADDR_W-1:0] newda_field(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction

endpackage

// File: rtl/i3c_ccc_tracker.sv
module i3c_ccc_tracker
  import i3c_ccc_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_hdr,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              hdr_rnw,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic              dyn_valid,
  input  logic [ADDR_W-1:0] static_addr,
  input  logic              legacy_mode,
  output logic              hdr_ack_vld,
  output logic              hdr_ack,
  output logic              code_evt,
  output ccc_cmd_e          code_cmd,
  output logic              pay_evt,
  output ccc_cmd_e          pay_cmd,
  output logic [CNT_W-1:0]  pay_idx,
  output logic              def_evt,
  output ccc_cmd_e          def_cmd,
  output logic              dir_hit,
  output ccc_cmd_e          dir_hit_cmd
);

  typedef enum logic [1:0] {SEC_IDLE, SEC_BCAST, SEC_DIRECT, SEC_PASS} sec_e;

  sec_e             sect;
  logic [CNT_W-1:0] bcount;
  logic             dir_active;
  ccc_cmd_e         dir_cmd;
  ccc_cmd_e         cur_cmd;

  logic dir_eff, hdr_is_bc, hdr_is_own, hdr_is_leg, refuse, ack_now;
  logic byte_bc, code_byte;

  assign dir_eff    = dir_active & ~ev_start;
  assign hdr_is_bc  = (hdr_addr == BCAST_ADDR) & ~hdr_rnw;
  assign hdr_is_own = dyn_valid & (hdr_addr == dyn_addr);
  assign hdr_is_leg = legacy_mode & (hdr_addr == static_addr);
  assign refuse     = hdr_is_own & dir_eff & (dir_cmd == CMD_RSTDAA);
  assign ack_now    = hdr_is_bc | (hdr_is_own & ~refuse) | hdr_is_leg;

  assign dir_hit     = ev_hdr & hdr_is_own & ~refuse & dir_eff & ~hdr_rnw & ~hdr_is_bc;
  assign dir_hit_cmd = dir_cmd;

  assign byte_bc   = ev_byte & (sect == SEC_BCAST);
  assign code_byte = byte_bc & (bcount == '0);
  assign code_evt  = code_byte & ~ccc_is_direct(byte_data);
  assign code_cmd  = ccc_decode(byte_data);
  assign def_evt   = byte_bc & (bcount == CNT_W'(1)) & dir_active;
  assign def_cmd   = dir_cmd;

  always_comb begin
    pay_evt = 1'b0;
    pay_cmd = CMD_NONE;
    pay_idx = '0;
    if (byte_bc && (bcount != '0) && !dir_active) begin
      pay_evt = 1'b1;
      pay_cmd = cur_cmd;
      pay_idx = bcount - CNT_W'(1);
    end else if (ev_byte && (sect == SEC_DIRECT)) begin
      pay_evt = 1'b1;
      pay_cmd = dir_cmd;
      pay_idx = bcount;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect        <= SEC_IDLE;
      bcount      <= '0;
      dir_active  <= 1'b0;
      dir_cmd     <= CMD_NONE;
      cur_cmd     <= CMD_NONE;
      hdr_ack_vld <= 1'b0;
      hdr_ack     <= 1'b0;
    end else begin
      hdr_ack_vld <= ev_hdr;
      hdr_ack     <= ev_hdr & ack_now;
      if (ev_stop) begin
        sect       <= SEC_IDLE;
        bcount     <= '0;
        dir_active <= 1'b0;
      end else if (ev_hdr) begin
        bcount <= '0;
        if (hdr_is_bc)    sect <= SEC_BCAST;
        else if (dir_hit) sect <= SEC_DIRECT;
        else              sect <= SEC_PASS;
        if (hdr_is_bc || ev_start) dir_active <= 1'b0;
      end else if (ev_start || ev_rstart) begin
        sect <= SEC_IDLE;
        if (ev_start) dir_active <= 1'b0;
      end else if (ev_byte) begin
        if (bcount != '1) bcount <= bcount + CNT_W'(1);
        if (code_byte) begin
          if (ccc_is_direct(byte_data)) begin
            dir_active <= 1'b1;
            dir_cmd    <= ccc_decode(byte_data);
          end else begin
            cur_cmd <= ccc_decode(byte_data);
          end
        end
      end
    end
  end

  // R2: one decision per header, exactly one cycle later
  a_r2_ack_follows_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr |=> hdr_ack_vld);
  a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hdr |=> !hdr_ack_vld);
  a_r2_bcast_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hdr && hdr_addr == BCAST_ADDR && !hdr_rnw) |=> hdr_ack);
  // R4: own address refused while a direct address reset is in scope
  a_r4_direct_reset_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hdr && dir_active && !ev_start && dir_cmd == CMD_RSTDAA && dyn_valid
     && hdr_addr == dyn_addr) |=> !hdr_ack);
  // R11: a stop ends any direct scope
  a_r11_stop_ends_scope: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !dir_active);

endmodule

// File: rtl/i3c_ccc_regs.sv
module i3c_ccc_regs
  import i3c_ccc_pkg::*;
#(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned LEN_W = 2*BYTE_W,
  parameter logic [BYTE_W-1:0] EVT_RST = 8'h0B,
  parameter logic [LEN_W-1:0]  MWL_RST = 16'h0100,
  parameter logic [LEN_W-1:0]  MRL_RST = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_stop,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] static_addr,
  input  logic              static_valid,
  input  logic              code_evt,
  input  ccc_cmd_e          code_cmd,
  input  logic              pay_evt,
  input  ccc_cmd_e          pay_cmd,
  input  logic [CNT_W-1:0]  pay_idx,
  input  logic              def_evt,
  input  ccc_cmd_e          def_cmd,
  input  logic              dir_hit,
  input  ccc_cmd_e          dir_hit_cmd,
  output logic [ADDR_W-1:0] dyn_addr,
  output logic              dyn_valid,
  output logic              legacy_mode,
  output logic [BYTE_W-1:0] evt_en,
  output logic [LEN_W-1:0]  max_wr_len,
  output logic [LEN_W-1:0]  max_rd_len,
  output logic [BYTE_W-1:0] rst_action
);

  logic [BYTE_W-1:0] len_hi;
  logic [BYTE_W-1:0] act_pend;
  logic              act_pend_v;
  logic              first_b, second_b;

  assign legacy_mode = static_valid & ~dyn_valid;
  assign first_b     = pay_evt & (pay_idx == CNT_W'(0));
  assign second_b    = pay_evt & (pay_idx == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dyn_addr   <= '0;
      dyn_valid  <= 1'b0;
      evt_en     <= EVT_RST;
      max_wr_len <= MWL_RST;
      max_rd_len <= MRL_RST;
      rst_action <= '0;
      len_hi     <= '0;
      act_pend   <= '0;
      act_pend_v <= 1'b0;
    end else begin
      if (code_evt) begin
        if (code_cmd == CMD_RSTDAA) dyn_valid <= 1'b0;
        if (code_cmd == CMD_SETAASA && static_valid) begin
          dyn_addr  <= static_addr;
          dyn_valid <= 1'b1;
        end
      end
      if (first_b) begin
        case (pay_cmd)
          CMD_ENEC:     evt_en <= evt_apply(evt_en, byte_data, 1'b1);
          CMD_DISEC:    evt_en <= evt_apply(evt_en, byte_data, 1'b0);
          CMD_SETMWL,
          CMD_SETMRL:   len_hi <= byte_data;
          CMD_RSTACT:   rst_action <= byte_data;
          CMD_SETNEWDA: begin
            dyn_addr  <= newda_field(byte_data);
            dyn_valid <= 1'b1;
          end
          default: ;
        endcase
      end
      if (second_b) begin
        if (pay_cmd == CMD_SETMWL) max_wr_len <= len_join(len_hi, byte_data);
        if (pay_cmd == CMD_SETMRL) max_rd_len <= len_join(len_hi, byte_data);
      end
      if (def_evt && def_cmd == CMD_RSTACT) begin
        act_pend   <= byte_data;
        act_pend_v <= 1'b1;
      end
      if (dir_hit && dir_hit_cmd == CMD_RSTACT && act_pend_v) rst_action <= act_pend;
      if (ev_stop) act_pend_v <= 1'b0;
    end
  end

  // R3: the address is only dropped by a broadcast address reset
  a_r3_addr_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dyn_valid) |-> $past(code_evt && code_cmd == CMD_RSTDAA));
  // R9 / R10: address changes only come from the two assigning commands
  a_r9_addr_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dyn_addr) |-> $past((code_evt && code_cmd == CMD_SETAASA) ||
                                 (pay_evt && pay_cmd == CMD_SETNEWDA)));
  // R5 / R6: the mask only moves on an enable or disable payload
  a_r5_evt_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evt_en) |-> $past(pay_evt && (pay_cmd == CMD_ENEC || pay_cmd == CMD_DISEC)));
  // R7: a length commits only on its second payload byte
  a_r7_wlen_full_payload: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(max_wr_len) |-> $past(pay_evt && pay_cmd == CMD_SETMWL && pay_idx == CNT_W'(1)));
  a_r7_rlen_full_payload: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(max_rd_len) |-> $past(pay_evt && pay_cmd == CMD_SETMRL && pay_idx == CNT_W'(1)));

endmodule

// File: rtl/i3c_tgt_ccc_wr.sv
module i3c_tgt_ccc_wr
  import i3c_ccc_pkg::*;
#(
  parameter int unsigned CNT_W = 2,
  parameter logic [7:0]  EVT_RST = 8'h0B,
  parameter logic [15:0] MWL_RST = 16'h0100,
  parameter logic [15:0] MRL_RST = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_rstart,
  input  logic        ev_stop,
  input  logic        ev_hdr,
  input  logic [6:0]  hdr_addr,
  input  logic        hdr_rnw,
  input  logic        ev_byte,
  input  logic [7:0]  byte_data,
  input  logic [6:0]  static_addr,
  input  logic        static_valid,
  output logic        hdr_ack_vld,
  output logic        hdr_ack,
  output logic [6:0]  dyn_addr,
  output logic        dyn_valid,
  output logic        legacy_mode,
  output logic [7:0]  evt_en,
  output logic [15:0] max_wr_len,
  output logic [15:0] max_rd_len,
  output logic [7:0]  rst_action
);

  localparam int unsigned LEN_W = 2*BYTE_W;

  logic             code_evt, pay_evt, def_evt, dir_hit;
  ccc_cmd_e         code_cmd, pay_cmd, def_cmd, dir_hit_cmd;
  logic [CNT_W-1:0] pay_idx;

  i3c_ccc_tracker #(.CNT_W(CNT_W)) u_tracker (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
    .ev_hdr(ev_hdr), .hdr_addr(hdr_addr), .hdr_rnw(hdr_rnw),
    .ev_byte(ev_byte), .byte_data(byte_data),
    .dyn_addr(dyn_addr), .dyn_valid(dyn_valid),
    .static_addr(static_addr), .legacy_mode(legacy_mode),
    .hdr_ack_vld(hdr_ack_vld), .hdr_ack(hdr_ack),
    .code_evt(code_evt), .code_cmd(code_cmd),
    .pay_evt(pay_evt), .pay_cmd(pay_cmd), .pay_idx(pay_idx),
    .def_evt(def_evt), .def_cmd(def_cmd),
    .dir_hit(dir_hit), .dir_hit_cmd(dir_hit_cmd)
  );

  i3c_ccc_regs #(
    .CNT_W(CNT_W), .LEN_W(LEN_W),
    .EVT_RST(EVT_RST), .MWL_RST(MWL_RST), .MRL_RST(MRL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .byte_data(byte_data),
    .static_addr(static_addr), .static_valid(static_valid),
    .code_evt(code_evt), .code_cmd(code_cmd),
    .pay_evt(pay_evt), .pay_cmd(pay_cmd), .pay_idx(pay_idx),
    .def_evt(def_evt), .def_cmd(def_cmd),
    .dir_hit(dir_hit), .dir_hit_cmd(dir_hit_cmd),
    .dyn_addr(dyn_addr), .dyn_valid(dyn_valid), .legacy_mode(legacy_mode),
    .evt_en(evt_en), .max_wr_len(max_wr_len), .max_rd_len(max_rd_len),
    .rst_action(rst_action)
  );

  // R1: no acknowledge decision is reported while in reset
  always_comb begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!hdr_ack_vld);
  end

endmodule

// File: tb/i3c_tgt_ccc_wr_bench.sv
module i3c_tgt_ccc_wr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_hdr = 0, hdr_rnw = 0, ev_byte = 0;
  logic [6:0]  hdr_addr = '0;
  logic [7:0]  byte_data = '0;
  logic [6:0]  static_addr = '0;
  logic        static_valid = 1'b0;
  logic        hdr_ack_vld, hdr_ack, dyn_valid, legacy_mode;
  logic [6:0]  dyn_addr;
  logic [7:0]  evt_en, rst_action;
  logic [15:0] max_wr_len, max_rd_len;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i3c_tgt_ccc_wr u_i3c_tgt_ccc_wr (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
    .ev_hdr(ev_hdr), .hdr_addr(hdr_addr), .hdr_rnw(hdr_rnw),
    .ev_byte(ev_byte), .byte_data(byte_data),
    .static_addr(static_addr), .static_valid(static_valid),
    .hdr_ack_vld(hdr_ack_vld), .hdr_ack(hdr_ack),
    .dyn_addr(dyn_addr), .dyn_valid(dyn_valid), .legacy_mode(legacy_mode),
    .evt_en(evt_en), .max_wr_len(max_wr_len), .max_rd_len(max_rd_len),
    .rst_action(rst_action)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // header pulse; returns ACK sampled one cycle later, and checks the valid strobe
  task automatic hdr(input logic [6:0] a, input logic rnw, input logic st,
                     input logic rs, output logic ack);
    @(negedge clk);
    ev_hdr = 1; hdr_addr = a; hdr_rnw = rnw; ev_start = st; ev_rstart = rs;
    @(negedge clk);
    ev_hdr = 0; ev_start = 0; ev_rstart = 0;
    ack = hdr_ack;
    chk("R2 ack strobe", {31'd0, hdr_ack_vld}, 32'd1);
  endtask

  task automatic wbyte(input logic [7:0] b, input logic with_stop);
    @(negedge clk);
    ev_byte = 1; byte_data = b; ev_stop = with_stop;
    @(negedge clk);
    ev_byte = 0; ev_stop = 0;
  endtask

  task automatic stop();
    @(negedge clk);
    ev_stop = 1;
    @(negedge clk);
    ev_stop = 0;
  endtask

  task automatic open_ccc(input logic [7:0] code);
    logic a;
    hdr(7'h7E, 1'b0, 1'b1, 1'b0, a);
    chk("R2 broadcast header acked", {31'd0, a}, 32'd1);
    wbyte(code, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 dyn_valid", {31'd0, dyn_valid}, 32'd0);
    chk("R1 evt_en", {24'd0, evt_en}, 32'h0B);
    chk("R1 max_wr_len", {16'd0, max_wr_len}, 32'h0100);
    chk("R1 max_rd_len", {16'd0, max_rd_len}, 32'h0100);
    chk("R1 rst_action", {24'd0, rst_action}, 32'd0);
    chk("R1 ack idle", {31'd0, hdr_ack_vld}, 32'd0);
  endtask

  task automatic t_setaasa();
    static_addr = 7'h2C; static_valid = 1'b1;
    @(negedge clk);
    chk("R3 legacy before assignment", {31'd0, legacy_mode}, 32'd1);
    open_ccc(8'h29); stop();
    chk("R10 dyn_addr", {25'd0, dyn_addr}, 32'h2C);
    chk("R10 dyn_valid", {31'd0, dyn_valid}, 32'd1);
    chk("R3 legacy off", {31'd0, legacy_mode}, 32'd0);
  endtask

  task automatic t_ack();
    logic a;
    hdr(7'h33, 1'b0, 1'b1, 1'b0, a);
    chk("R2 foreign address nacked", {31'd0, a}, 32'd0);
    hdr(7'h2C, 1'b1, 1'b0, 1'b1, a);
    chk("R2 own address acked", {31'd0, a}, 32'd1);
    stop();
  endtask

  task automatic t_events();
    logic a;
    open_ccc(8'h01); wbyte(8'h09, 1'b0); stop();
    chk("R6 broadcast disable", {24'd0, evt_en}, 32'h02);
    open_ccc(8'h00); wbyte(8'h40, 1'b0); stop();
    chk("R5 broadcast enable", {24'd0, evt_en}, 32'h42);
    open_ccc(8'h80); hdr(7'h2C, 1'b0, 1'b0, 1'b1, a); wbyte(8'h01, 1'b0); stop();
    chk("R5 direct enable", {24'd0, evt_en}, 32'h43);
    open_ccc(8'h81); hdr(7'h2C, 1'b0, 1'b0, 1'b1, a); wbyte(8'h42, 1'b0); stop();
    chk("R6 direct disable", {24'd0, evt_en}, 32'h01);
  endtask

  task automatic t_scope();
    logic a;
    open_ccc(8'h80); hdr(7'h33, 1'b0, 1'b0, 1'b1, a); wbyte(8'hF0, 1'b0); stop();
    chk("R11 other target payload", {24'd0, evt_en}, 32'h01);
    open_ccc(8'h80); hdr(7'h7E, 1'b0, 1'b0, 1'b1, a);
    hdr(7'h2C, 1'b0, 1'b0, 1'b1, a); wbyte(8'hF0, 1'b0); stop();
    chk("R11 scope ended by 0x7E header", {24'd0, evt_en}, 32'h01);
    open_ccc(8'h80); stop();
    hdr(7'h2C, 1'b0, 1'b1, 1'b0, a); wbyte(8'hF0, 1'b0); stop();
    chk("R11 scope ended by stop", {24'd0, evt_en}, 32'h01);
  endtask

  task automatic t_len();
    logic a;
    open_ccc(8'h09); wbyte(8'h12, 1'b0); wbyte(8'h34, 1'b0); stop();
    chk("R7 broadcast write length", {16'd0, max_wr_len}, 32'h1234);
    open_ccc(8'h0A); wbyte(8'h55, 1'b0); stop();
    chk("R7 short payload ignored", {16'd0, max_rd_len}, 32'h0100);
    open_ccc(8'h8A); hdr(7'h2C, 1'b0, 1'b0, 1'b1, a);
    wbyte(8'h00, 1'b0); wbyte(8'h40, 1'b0); wbyte(8'h99, 1'b0); stop();
    chk("R7 direct read length, extra byte ignored", {16'd0, max_rd_len}, 32'h0040);
    open_ccc(8'h09); wbyte(8'hAB, 1'b0); wbyte(8'hCD, 1'b1);
    chk("R12 last byte with stop commits", {16'd0, max_wr_len}, 32'hABCD);
    chk("R7 other length untouched", {16'd0, max_rd_len}, 32'h0040);
  endtask

  task automatic t_rstact();
    logic a;
    open_ccc(8'h2A); wbyte(8'h01, 1'b0); stop();
    chk("R8 broadcast reset action", {24'd0, rst_action}, 32'h01);
    open_ccc(8'h9A); wbyte(8'h02, 1'b0); hdr(7'h2C, 1'b0, 1'b0, 1'b1, a); stop();
    chk("R8 direct reset action", {24'd0, rst_action}, 32'h02);
    open_ccc(8'h9A); wbyte(8'h03, 1'b0); hdr(7'h33, 1'b0, 1'b0, 1'b1, a); stop();
    chk("R8 direct to other target ignored", {24'd0, rst_action}, 32'h02);
  endtask

  task automatic t_newda();
    logic a;
    open_ccc(8'h88); hdr(7'h2C, 1'b0, 1'b0, 1'b1, a);
    chk("R9 own header acked", {31'd0, a}, 32'd1);
    wbyte(8'hB4, 1'b0);
    hdr(7'h5A, 1'b0, 1'b0, 1'b1, a);
    chk("R12 new address acked next cycle", {31'd0, a}, 32'd1);
    stop();
    chk("R9 new dynamic address", {25'd0, dyn_addr}, 32'h5A);
    hdr(7'h2C, 1'b0, 1'b1, 1'b0, a); stop();
    chk("R9 old address refused", {31'd0, a}, 32'd0);
  endtask

  task automatic t_rstdaa();
    logic a;
    open_ccc(8'h86); hdr(7'h5A, 1'b0, 1'b0, 1'b1, a); stop();
    chk("R4 direct reset nacked", {31'd0, a}, 32'd0);
    chk("R4 address kept", {24'd0, dyn_valid, dyn_addr}, {24'd0, 1'b1, 7'h5A});
    open_ccc(8'h06); stop();
    chk("R3 address cleared", {31'd0, dyn_valid}, 32'd0);
    chk("R3 legacy fallback", {31'd0, legacy_mode}, 32'd1);
    hdr(7'h2C, 1'b0, 1'b1, 1'b0, a); stop();
    chk("R3 static address acked", {31'd0, a}, 32'd1);
    static_valid = 1'b0;
    @(negedge clk);
    chk("R3 no static, waits unaddressed", {31'd0, legacy_mode}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setaasa();
    t_ack();
    t_events();
    t_scope();
    t_len();
    t_rstact();
    t_newda();
    t_rstdaa();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

endmodule